// File: doc/BRIEF.md
# Burst Command Sequencer

The block is the synchronous control core of a burst-capable static memory. Each rising clock edge samples a three-bit command and an address. A command whose top bit is low loads a new burst base and starts a read or a write at single or double data rate. Other commands either extend the running burst or idle the memory. From its registered state the sequencer drives, for every data beat, a word address and a read or write strobe on one of two lanes: lane 0 for the rising half of the cycle and lane 1 for the falling half.

A burst covers at most four words inside an aligned four-word window. A Continue command steps the beat index by one (single rate) or by two (double rate) and wraps back to the base word. The low two address bits follow one of two orders, chosen by a mode pin: linear (index added modulo 4) or interleaved (index XORed into the base). Writes use a late-write scheme. Data is captured one cycle after the command and parked in a two-entry write buffer. The buffer is flushed to a behavioural array on the next write, and reads forward from it, so every read returns the newest data. Read data leaves one cycle after the strobe cycle, behind an asynchronous active-low output enable.

Top module: `burst_seq`

## Requirements
- R1: With cmd_i[2]=0 the command loads a new burst. cmd_i[1] selects read (1) or write (0) and cmd_i[0] selects single (1) or double (0) rate. After the edge, op_o reads 1 for single read, 2 for single write, 3 for double read and 4 for double write, and beat_addr_rise_o equals the sampled addr_i.
- R2: cmd_i[2:1]=2'b11 (Continue) leaves op_o unchanged. cmd_i[2:1]=2'b10 (Deselect) sets op_o to 0 and clears all strobes. A Continue issued while op_o is 0 keeps op_o at 0 with no strobes.
- R3: A Continue advances the beat index by 1 after a single-rate load and by 2 after a double-rate load, modulo 4. The fourth single-rate Continue, or the second double-rate Continue, returns to the base word.
- R4: With order_i=1 the low two address bits are base XOR index. With order_i=0 they are base plus index modulo 4. Bits above the low two stay at the base value for the whole burst.
- R5: Strobe bit 0 is the rising-half lane and bit 1 the falling-half lane. Strobes are active in the cycle after the command edge. Lane 1 is active only at double rate, and its address uses the beat index plus one.
- R6: Write data on wdata_rise_i/wdata_fall_i is captured at the edge that ends the write strobe cycle. Read data appears on rdata_rise_o/rdata_fall_o from the edge that ends the read strobe cycle.
- R7: A read returns the most recent data written to that word, including data still held in the write buffer. The buffer is committed to the array when the next write beat arrives.
- R8: dq_oe_o is high in the cycle after a read strobe cycle, and only while oe_ni is low. oe_ni acts on dq_oe_o without waiting for a clock edge.
- R9: After reset, op_o is 0, all strobes are low and dq_oe_o is low.
- R10: Every new-address command restarts the beat index at zero, even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: [2] load_n, [1] read/continue, [0] single rate |
| addr_i | input | AW | Burst base address, sampled on load |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_rise_i | input | DW | Write data, rising-half beat |
| wdata_fall_i | input | DW | Write data, falling-half beat |
| beat_addr_rise_o | output | AW | Word address of rising-half beat |
| beat_addr_fall_o | output | AW | Word address of falling-half beat |
| rd_stb_o | output | 2 | Read strobe per lane ([0] rise, [1] fall) |
| wr_stb_o | output | 2 | Write strobe per lane ([0] rise, [1] fall) |
| op_o | output | 3 | Current operation code |
| dq_oe_o | output | 1 | Data bus drive enable |
| rdata_rise_o | output | DW | Read data, rising-half beat |
| rdata_fall_o | output | DW | Read data, falling-half beat |

## Verification
The bench checks the wrap point in both rates. A wrong step size or a wrong wrap leaves the fifth single-rate beat or the third double-rate beat on a different word than the base. Both orders start from a base whose low bits are non-zero. A design that swapped the orders, or that added a carry into the upper bits, then emits a different sequence. A read issued right after a double-rate write, to a word that exists only in the write buffer, catches a design without forwarding: it would return stale or unknown data. Further cases cover a reload in the middle of a burst, a Continue from deselect, and toggling the output enable between edges. These catch a counter that is not cleared, a phantom strobe, and an enable that is registered when it should be asynchronous.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_SRD  = 3'd1,
    OP_SWR  = 3'd2,
    OP_DRD  = 3'd3,
    OP_DWR  = 3'd4
  } op_e;

  function automatic logic is_ddr(input op_e op);
    return (op == OP_DRD) || (op == OP_DWR);
  endfunction

  function automatic logic is_rd(input op_e op);
    return (op == OP_SRD) || (op == OP_DRD);
  endfunction

  function automatic logic is_wr(input op_e op);
    return (op == OP_SWR) || (op == OP_DWR);
  endfunction

  // low two address bits of a beat inside the four-word window
  function automatic logic [1:0] seq_low(input logic [1:0] base, input logic [1:0] idx,
                                         input logic interleave);
    return interleave ? (base ^ idx) : (base + idx);
  endfunction
endpackage

// File: rtl/burst_cmd_ctrl.sv
module burst_cmd_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  output op_e           op_o,
  output logic [AW-1:0] base_o,
  output logic [1:0]    idx_o
);
  op_e           op_q;
  logic [AW-1:0] base_q;
  logic [1:0]    idx_q;
  op_e           load_op;

  always_comb begin
    unique case (cmd_i[1:0])
      2'b11:   load_op = OP_SRD;
      2'b10:   load_op = OP_DRD;
      2'b01:   load_op = OP_SWR;
      default: load_op = OP_DWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      idx_q  <= '0;
    end else if (!cmd_i[2]) begin
      op_q   <= load_op;
      base_q <= addr_i;
      idx_q  <= '0;
    end else if (cmd_i[1]) begin
      // continue; from idle nothing moves
      if (op_q != OP_IDLE) idx_q <= idx_q + (is_ddr(op_q) ? 2'd2 : 2'd1);
    end else begin
      op_q <= OP_IDLE;
    end
  end

  assign op_o   = op_q;
  assign base_o = base_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  op_e                       op_i,
  input  logic [AW-1:0]             base_i,
  input  logic [1:0]                idx_i,
  input  logic                      order_i,
  output logic [LANES-1:0][AW-1:0]  lane_addr_o,
  output logic [LANES-1:0]          rd_stb_o,
  output logic [LANES-1:0]          wr_stb_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic act;
    logic [1:0] beat;
    assign beat = idx_i + 2'(g);
    if (g == 0) begin : g_first
      assign act = (op_i != OP_IDLE);
    end else begin : g_second
      assign act = is_ddr(op_i);
    end
    assign lane_addr_o[g] = {base_i[AW-1:2], seq_low(base_i[1:0], beat, order_i)};
    assign rd_stb_o[g]    = act & is_rd(op_i);
    assign wr_stb_o[g]    = act & is_wr(op_i);
  end
endmodule

// File: rtl/burst_wbuf_mem.sv
module burst_wbuf_mem
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES-1:0][AW-1:0]  lane_addr_i,
  input  logic [LANES-1:0]          rd_stb_i,
  input  logic [LANES-1:0]          wr_stb_i,
  input  logic [LANES-1:0][DW-1:0]  wdata_i,
  output logic [LANES-1:0][DW-1:0]  rdata_o,
  output logic                      rd_q_o
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0]             mem [DEPTH];
  logic [LANES-1:0]          wb_vld;
  logic [LANES-1:0][AW-1:0]  wb_addr;
  logic [LANES-1:0][DW-1:0]  wb_data;
  logic [LANES-1:0][DW-1:0]  rd_word;
  logic [LANES-1:0][DW-1:0]  rdata_q;
  logic                      rd_q;
  logic                      any_wr;

  assign any_wr = |wr_stb_i;

  // late write: park new beats, commit previous ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_vld  <= '0;
      wb_addr <= '0;
      wb_data <= '0;
    end else if (any_wr) begin
      wb_vld  <= wr_stb_i;
      wb_addr <= lane_addr_i;
      wb_data <= wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (any_wr) begin
      for (int i = 0; i < int'(LANES); i++) begin
        if (wb_vld[i]) mem[wb_addr[i]] <= wb_data[i];
      end
    end
  end

  // forward from the buffer, newest lane first
  always_comb begin
    for (int l = 0; l < int'(LANES); l++) begin
      rd_word[l] = mem[lane_addr_i[l]];
      for (int e = 0; e < int'(LANES); e++) begin
        if (wb_vld[e] && (wb_addr[e] == lane_addr_i[l])) rd_word[l] = wb_data[e];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      rd_q <= |rd_stb_i;
      for (int l = 0; l < int'(LANES); l++) begin
        if (rd_stb_i[l]) rdata_q[l] <= rd_word[l];
      end
    end
  end

  assign rdata_o = rdata_q;
  assign rd_q_o  = rd_q;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          order_i,
  input  logic          oe_ni,
  input  logic [DW-1:0] wdata_rise_i,
  input  logic [DW-1:0] wdata_fall_i,
  output logic [AW-1:0] beat_addr_rise_o,
  output logic [AW-1:0] beat_addr_fall_o,
  output logic [1:0]    rd_stb_o,
  output logic [1:0]    wr_stb_o,
  output logic [2:0]    op_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] rdata_rise_o,
  output logic [DW-1:0] rdata_fall_o
);
  op_e                       op;
  logic [AW-1:0]             base;
  logic [1:0]                idx;
  logic [LANES-1:0][AW-1:0]  lane_addr;
  logic [LANES-1:0]          rd_stb;
  logic [LANES-1:0]          wr_stb;
  logic [LANES-1:0][DW-1:0]  wdata;
  logic [LANES-1:0][DW-1:0]  rdata;
  logic                      rd_q;

  burst_cmd_ctrl #(.AW(AW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_i),
    .addr_i (addr_i),
    .op_o   (op),
    .base_o (base),
    .idx_o  (idx)
  );

  burst_addr_gen #(.AW(AW)) u_agen (
    .op_i        (op),
    .base_i      (base),
    .idx_i       (idx),
    .order_i     (order_i),
    .lane_addr_o (lane_addr),
    .rd_stb_o    (rd_stb),
    .wr_stb_o    (wr_stb)
  );

  assign wdata = {wdata_fall_i, wdata_rise_i};

  burst_wbuf_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lane_addr_i (lane_addr),
    .rd_stb_i    (rd_stb),
    .wr_stb_i    (wr_stb),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .rd_q_o      (rd_q)
  );

  assign beat_addr_rise_o = lane_addr[0];
  assign beat_addr_fall_o = lane_addr[1];
  assign rd_stb_o         = rd_stb;
  assign wr_stb_o         = wr_stb;
  assign op_o             = op;
  assign rdata_rise_o     = rdata[0];
  assign rdata_fall_o     = rdata[1];
  assign dq_oe_o          = rd_q & ~oe_ni;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    cmd_i,
  input logic [AW-1:0] addr_i,
  input logic          order_i,
  input logic          oe_ni,
  input logic [AW-1:0] beat_addr_rise_o,
  input logic [AW-1:0] beat_addr_fall_o,
  input logic [1:0]    rd_stb_o,
  input logic [1:0]    wr_stb_o,
  input logic [2:0]    op_o,
  input logic          dq_oe_o
);
  assert_load_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i[2] |=> beat_addr_rise_o == $past(addr_i));

  assert_load_sdr_rd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 3'b011 |=> op_o == 3'd1);

  assert_cont_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i[2:1] == 2'b11 |=> $stable(op_o));

  assert_desel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i[2:1] == 2'b10 |=> (op_o == 3'd0 && rd_stb_o == 2'b00 && wr_stb_o == 2'b00));

  assert_sdr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[2:1] == 2'b11 && (op_o == 3'd1 || op_o == 3'd2) && !order_i && $stable(order_i))
    |=> beat_addr_rise_o[1:0] == $past(beat_addr_rise_o[1:0]) + 2'd1);

  assert_upper_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[2:1] == 2'b11 && op_o != 3'd0)
    |=> beat_addr_rise_o[AW-1:2] == $past(beat_addr_rise_o[AW-1:2]));

  assert_fall_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_o == 3'd3 || op_o == 3'd4) && order_i) |-> beat_addr_fall_o == (beat_addr_rise_o ^ AW'(1)));

  assert_sdr_one_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == 3'd1 || op_o == 3'd2) |-> (!rd_stb_o[1] && !wr_stb_o[1]));

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_stb_o[0], wr_stb_o[0]}));

  assert_oe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  assert_oe_after_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> $past(rd_stb_o[0]));
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cmd_i            (cmd_i),
  .addr_i           (addr_i),
  .order_i          (order_i),
  .oe_ni            (oe_ni),
  .beat_addr_rise_o (beat_addr_rise_o),
  .beat_addr_fall_o (beat_addr_fall_o),
  .rd_stb_o         (rd_stb_o),
  .wr_stb_o         (wr_stb_o),
  .op_o             (op_o),
  .dq_oe_o          (dq_oe_o)
);

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;

  localparam logic [2:0] C_SRD  = 3'b011;
  localparam logic [2:0] C_DRD  = 3'b010;
  localparam logic [2:0] C_SWR  = 3'b001;
  localparam logic [2:0] C_DWR  = 3'b000;
  localparam logic [2:0] C_CONT = 3'b110;
  localparam logic [2:0] C_DSEL = 3'b100;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    cmd_i = C_DSEL;
  logic [AW-1:0] addr_i = '0;
  logic          order_i = 1'b0;
  logic          oe_ni = 1'b0;
  logic [DW-1:0] wdata_rise_i = '0;
  logic [DW-1:0] wdata_fall_i = '0;
  logic [AW-1:0] beat_addr_rise_o, beat_addr_fall_o;
  logic [1:0]    rd_stb_o, wr_stb_o;
  logic [2:0]    op_o;
  logic          dq_oe_o;
  logic [DW-1:0] rdata_rise_o, rdata_fall_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_seq #(.AW(AW), .DW(DW)) u_burst_seq (
    .clk_i            (clk),
    .rst_ni           (rst_ni),
    .cmd_i            (cmd_i),
    .addr_i           (addr_i),
    .order_i          (order_i),
    .oe_ni            (oe_ni),
    .wdata_rise_i     (wdata_rise_i),
    .wdata_fall_i     (wdata_fall_i),
    .beat_addr_rise_o (beat_addr_rise_o),
    .beat_addr_fall_o (beat_addr_fall_o),
    .rd_stb_o         (rd_stb_o),
    .wr_stb_o         (wr_stb_o),
    .op_o             (op_o),
    .dq_oe_o          (dq_oe_o),
    .rdata_rise_o     (rdata_rise_o),
    .rdata_fall_o     (rdata_fall_o)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int idx, input logic il);
    logic [1:0] i2;
    i2 = 2'(idx);
    return {b[AW-1:2], il ? (b[1:0] ^ i2) : (b[1:0] + i2)};
  endfunction

  function automatic logic [DW-1:0] wd(input logic [AW-1:0] a, input logic [DW-1:0] salt);
    return {a, 2'b01} ^ salt;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge; wr/wf feed the previous command
  task automatic cyc(input logic [2:0] c, input logic [AW-1:0] a,
                     input logic [DW-1:0] wr, input logic [DW-1:0] wf);
    cmd_i = c;
    addr_i = a;
    wdata_rise_i = wr;
    wdata_fall_i = wf;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 op", 32'(op_o), 32'd0);
    chk("R9 rd_stb", 32'(rd_stb_o), 32'd0);
    chk("R9 wr_stb", 32'(wr_stb_o), 32'd0);
    chk("R9 dq_oe", 32'(dq_oe_o), 32'd0);
  endtask

  task automatic t_sdr_write_linear;
    logic [AW-1:0] base, prev;
    order_i = 1'b0;
    base = 6'h15;
    cyc(C_SWR, base, '0, '0);
    chk("R1 op single write", 32'(op_o), 32'd2);
    chk("R1 load addr", 32'(beat_addr_rise_o), 32'(base));
    chk("R5 single strobe", 32'(wr_stb_o), 32'b01);
    prev = beat_addr_rise_o;
    for (int i = 1; i <= 4; i++) begin
      cyc(C_CONT, '0, wd(prev, 8'h3C), '0);
      chk("R3 R4 linear step", 32'(beat_addr_rise_o), 32'(exp_addr(base, i, 1'b0)));
      chk("R2 continue keeps op", 32'(op_o), 32'd2);
      prev = beat_addr_rise_o;
    end
    cyc(C_DSEL, '0, wd(prev, 8'h3C), '0);
    chk("R2 deselect op", 32'(op_o), 32'd0);
    chk("R2 deselect strobes", 32'({rd_stb_o, wr_stb_o}), 32'd0);
    cyc(C_CONT, '0, '0, '0);
    chk("R2 continue from deselect", 32'(op_o), 32'd0);
    chk("R2 no strobe from deselect", 32'({rd_stb_o, wr_stb_o}), 32'd0);
  endtask

  task automatic t_ddr_write_interleave;
    logic [AW-1:0] base, pr, pf;
    order_i = 1'b1;
    base = 6'h2A;
    cyc(C_DWR, base, '0, '0);
    chk("R1 op double write", 32'(op_o), 32'd4);
    chk("R5 both lanes", 32'(wr_stb_o), 32'b11);
    chk("R4 rise beat0", 32'(beat_addr_rise_o), 32'(exp_addr(base, 0, 1'b1)));
    chk("R5 fall beat1", 32'(beat_addr_fall_o), 32'(exp_addr(base, 1, 1'b1)));
    pr = beat_addr_rise_o;
    pf = beat_addr_fall_o;
    for (int i = 1; i <= 2; i++) begin
      cyc(C_CONT, '0, wd(pr, 8'h3C), wd(pf, 8'h3C));
      chk("R3 double step rise", 32'(beat_addr_rise_o), 32'(exp_addr(base, 2 * i, 1'b1)));
      chk("R3 double step fall", 32'(beat_addr_fall_o), 32'(exp_addr(base, 2 * i + 1, 1'b1)));
      pr = beat_addr_rise_o;
      pf = beat_addr_fall_o;
    end
    cyc(C_DSEL, '0, wd(pr, 8'h3C), wd(pf, 8'h3C));
  endtask

  task automatic t_reads;
    order_i = 1'b0;
    cyc(C_DRD, 6'h14, '0, '0);
    chk("R1 op double read", 32'(op_o), 32'd3);
    chk("R5 read lanes", 32'(rd_stb_o), 32'b11);
    chk("R5 linear fall", 32'(beat_addr_fall_o), 32'h15);
    cyc(C_DSEL, '0, '0, '0);
    chk("R6 rise data", 32'(rdata_rise_o), 32'(wd(6'h14, 8'h3C)));
    chk("R6 fall data", 32'(rdata_fall_o), 32'(wd(6'h15, 8'h3C)));
    chk("R8 oe after read", 32'(dq_oe_o), 32'd1);
    cyc(C_DSEL, '0, '0, '0);
    chk("R8 oe released", 32'(dq_oe_o), 32'd0);
    // single read burst, data trails address by a cycle
    cyc(C_SRD, 6'h16, '0, '0);
    chk("R4 read base", 32'(beat_addr_rise_o), 32'h16);
    cyc(C_CONT, '0, '0, '0);
    chk("R6 sdr data 16", 32'(rdata_rise_o), 32'(wd(6'h16, 8'h3C)));
    chk("R3 sdr read step", 32'(beat_addr_rise_o), 32'h17);
    cyc(C_DSEL, '0, '0, '0);
    chk("R6 sdr data 17", 32'(rdata_rise_o), 32'(wd(6'h17, 8'h3C)));
    // interleaved burst: 0x28/0x29 committed, 0x2A/0x2B still buffered
    order_i = 1'b1;
    cyc(C_DRD, 6'h29, '0, '0);
    chk("R4 interleave fall", 32'(beat_addr_fall_o), 32'h28);
    cyc(C_CONT, '0, '0, '0);
    chk("R6 committed 29", 32'(rdata_rise_o), 32'(wd(6'h29, 8'h3C)));
    chk("R3 interleave wrap step", 32'(beat_addr_rise_o), 32'h2B);
    cyc(C_DSEL, '0, '0, '0);
    chk("R7 buffered 2B", 32'(rdata_rise_o), 32'(wd(6'h2B, 8'h3C)));
    chk("R7 buffered 2A", 32'(rdata_fall_o), 32'(wd(6'h2A, 8'h3C)));
  endtask

  task automatic t_coherence;
    order_i = 1'b1;
    cyc(C_DWR, 6'h3C, '0, '0);
    cyc(C_SRD, 6'h3D, wd(6'h3C, 8'hC3), wd(6'h3D, 8'hC3));
    chk("R1 read after write", 32'(op_o), 32'd1);
    cyc(C_DSEL, '0, '0, '0);
    chk("R7 forward newest", 32'(rdata_rise_o), 32'(wd(6'h3D, 8'hC3)));
  endtask

  task automatic t_oe;
    order_i = 1'b0;
    cyc(C_SRD, 6'h14, '0, '0);
    cyc(C_DSEL, '0, '0, '0);
    oe_ni = 1'b1;
    #1;
    chk("R8 oe async off", 32'(dq_oe_o), 32'd0);
    oe_ni = 1'b0;
    #1;
    chk("R8 oe async on", 32'(dq_oe_o), 32'd1);
    chk("R6 data under oe", 32'(rdata_rise_o), 32'(wd(6'h14, 8'h3C)));
    @(negedge clk);
  endtask

  task automatic t_reload;
    order_i = 1'b0;
    cyc(C_SRD, 6'h20, '0, '0);
    cyc(C_CONT, '0, '0, '0);
    chk("R3 step before reload", 32'(beat_addr_rise_o), 32'h21);
    cyc(C_SRD, 6'h33, '0, '0);
    chk("R10 reload index zero", 32'(beat_addr_rise_o), 32'h33);
    cyc(C_CONT, '0, '0, '0);
    chk("R10 R4 wrap in window", 32'(beat_addr_rise_o), 32'h30);
    cyc(C_DSEL, '0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_sdr_write_linear;
    t_ddr_write_interleave;
    t_reads;
    t_coherence;
    t_oe;
    t_reload;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule